// File: doc/BRIEF.md
# SD Video LSB Dither

This block sits in the transmit path of a standard-definition serial video link. It takes 10-bit video samples and randomizes the two least significant bits of picture samples. The random bits come from a free-running pseudo-random shift register. This breaks up the long repeated data runs that can upset a serializer's scrambler and equalizer. The upstream framer must mark each sample with two flags. One flag says whether the sample is in active picture. The other says whether the line belongs to the vertical blanking interval. Timing reference words and ancillary data are never flagged as active, so the block passes them through untouched.

There are two enables. One covers the active picture of ordinary lines. The other extends dither to the picture-width portion of vertical-blanking lines. Samples whose upper eight bits are all zeros or all ones are never dithered. Because of this guard, a dithered sample can never land on a reserved code. The block adds one register of latency on every path.

Top module: `sd_dither`

## Requirements
- R1: While `rst` is high at a rising clock edge, `smp_out` becomes 000h at that edge.
- R2: `smp_out` is the sample presented one clock earlier. When both enables are low, it is that sample exactly.
- R3: Bits [9:2] of `smp_out` always equal bits [9:2] of the sample presented one clock earlier.
- R4: On an ordinary line (`act_in`=1, `vbi_in`=0) with `dith_en`=1 and an unprotected sample, `smp_out[1:0]` is set to the generator's bits [1:0] as they stood at the capturing edge.
- R5: A sample with `act_in`=0 is never altered, whatever the enables.
- R6: On a vertical-blanking line (`act_in`=1, `vbi_in`=1), a sample is dithered only when `dith_en` and `vdith_en` are both 1. Otherwise it passes unchanged.
- R7: A sample whose bits [9:2] are 00h or FFh passes unchanged. An output built from any other input is never in 000h–003h or 3FCh–3FFh.
- R8: The generator is a 15-bit shift register loaded with 0001h during reset. On every clock edge without reset it shifts left, and its new bit 0 is bit 14 XOR bit 13. It advances whether or not the sample is dithered, and it never holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 10 | Incoming video sample |
| act_in | input | 1 | Sample lies in the active-picture part of its line |
| vbi_in | input | 1 | Current line belongs to the vertical blanking interval |
| dith_en | input | 1 | Dither enable for active picture |
| vdith_en | input | 1 | Extends dither to active-width part of blanking lines |
| smp_out | output | 10 | Sample after dither, one clock later |

## Verification
A wrong generator state shows up on the first dithered sample. Its low bits would stop following the x^15+x^14+1 sequence counted from reset, and the bench compares them on every cycle. A wrong gating decision shows up in the very next output word. That word would either alter a sample that should pass (blanking, timing words, protected codes, disabled regions) or leave a picture sample unrandomized. The bench sweeps every 10-bit code under all sixteen flag and enable combinations, so any such error appears within one clock of the sample that triggers it.

// File: rtl/sd_dither_pkg.sv
package sd_dither_pkg;

    localparam int SMP_W  = 10;
    localparam int DITH_W = 2;
    localparam int UPPER_W = SMP_W - DITH_W;
    localparam int LFSR_W = 15;
    localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

    typedef logic [SMP_W-1:0]  sample_t;
    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic [1:0] {
        REGION_PASS    = 2'd0,
        REGION_PICTURE = 2'd1,
        REGION_VBI     = 2'd2
    } region_e;

    typedef struct packed {
        sample_t smp;
        logic    act;
        logic    vbi;
    } vid_word_t;

    // Fibonacci step for x^15 + x^14 + 1
    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    endfunction

    // Upper field all zeros or all ones: dither could reach a reserved code
    function automatic logic is_guarded(input sample_t s);
        logic [UPPER_W-1:0] up;
        up = s[SMP_W-1:DITH_W];
        return (up == '0) || (up == '1);
    endfunction

endpackage

// File: rtl/sd_dither_lfsr.sv
module sd_dither_lfsr
    import sd_dither_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [DITH_W-1:0] rnd
);

    lfsr_t state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= LFSR_SEED;
        else     state_q <= lfsr_step(state_q);
    end

    assign rnd = state_q[DITH_W-1:0];

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (state_q != '0)); // R8

endmodule

// File: rtl/sd_dither_gate.sv
module sd_dither_gate
    import sd_dither_pkg::*;
(
    input  vid_word_t word,
    input  logic      dith_en,
    input  logic      vdith_en,
    output region_e   region,
    output logic      apply
);

    always_comb begin
        if (!word.act)     region = REGION_PASS;
        else if (word.vbi) region = REGION_VBI;
        else               region = REGION_PICTURE;
    end

    always_comb begin
        unique case (region)
            REGION_PICTURE: apply = dith_en;
            REGION_VBI:     apply = dith_en && vdith_en;
            default:        apply = 1'b0;
        endcase
        if (is_guarded(word.smp)) apply = 1'b0;
    end

endmodule

// File: rtl/sd_dither.sv
module sd_dither
    import sd_dither_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [9:0] smp_in,
    input  logic       act_in,
    input  logic       vbi_in,
    input  logic       dith_en,
    input  logic       vdith_en,
    output logic [9:0] smp_out
);

    vid_word_t         word;
    region_e           region;
    logic              apply;
    logic [DITH_W-1:0] rnd;
    sample_t           smp_q;

    assign word = '{smp: smp_in, act: act_in, vbi: vbi_in};

    sd_dither_lfsr i_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    sd_dither_gate i_gate (
        .word     (word),
        .dith_en  (dith_en),
        .vdith_en (vdith_en),
        .region   (region),
        .apply    (apply)
    );

    always_ff @(posedge clk) begin
        if (rst)        smp_q <= '0;
        else if (apply) smp_q <= {word.smp[SMP_W-1:DITH_W], rnd};
        else            smp_q <= word.smp;
    end

    assign smp_out = smp_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (smp_out == '0)); // R1
    AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (rst)
        (!dith_en && !vdith_en) |=> (smp_out == $past(smp_in))); // R2
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (smp_out[9:2] == $past(smp_in[9:2]))); // R3
    AST_BLANK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !act_in |=> (smp_out == $past(smp_in))); // R5
    AST_VBI_GATED: assert property (@(posedge clk) disable iff (rst)
        (act_in && vbi_in && !(dith_en && vdith_en)) |=> (smp_out == $past(smp_in))); // R6
    AST_GUARD_PASS: assert property (@(posedge clk) disable iff (rst)
        is_guarded(smp_in) |=> (smp_out == $past(smp_in))); // R7
    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
        !is_guarded(smp_in) |=> !is_guarded(smp_out)); // R7

endmodule

// File: tb/test_sd_dither.sv
`timescale 1ns/1ps
module test_sd_dither;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] smp_in = '0;
    logic       act_in = 1'b0;
    logic       vbi_in = 1'b0;
    logic       dith_en = 1'b0;
    logic       vdith_en = 1'b0;
    logic [9:0] smp_out;

    int checks = 0;
    int errors = 0;
    logic [14:0] m;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sd_dither i_sd_dither (
        .clk      (clk),
        .rst      (rst),
        .smp_in   (smp_in),
        .act_in   (act_in),
        .vbi_in   (vbi_in),
        .dith_en  (dith_en),
        .vdith_en (vdith_en),
        .smp_out  (smp_out)
    );

    task automatic check(input logic [9:0] act, input logic [9:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %03h expected %03h", req, act, exp);
        end
    endtask

    // c = {act, vbi, dith_en, vdith_en}
    task automatic step(input logic [9:0] d, input logic [3:0] c);
        logic       prot;
        logic       app;
        logic [9:0] exp;
        string      tag;
        smp_in = d; act_in = c[3]; vbi_in = c[2]; dith_en = c[1]; vdith_en = c[0];
        @(posedge clk);
        prot = (d[9:2] == 8'h00) || (d[9:2] == 8'hFF);
        app  = c[3] && !prot && (c[2] ? (c[1] && c[0]) : c[1]);
        exp  = app ? {d[9:2], m[1:0]} : d;
        if (prot)                tag = "R7";
        else if (!c[3])          tag = "R5";
        else if (c[2])           tag = "R6";
        else if (c[1])           tag = "R4 R8";
        else                     tag = "R2";
        m = {m[13:0], m[14] ^ m[13]};
        @(negedge clk);
        check(smp_out, exp, tag);
        check({smp_out[9:2], 2'b00}, {d[9:2], 2'b00}, "R3");
        if (!prot) begin
            checks++;
            if ((smp_out[9:2] == 8'h00) || (smp_out[9:2] == 8'hFF)) begin
                errors++;
                $display("FAIL R7: got reserved %03h expected non-reserved", smp_out);
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_in = 10'h2A5; act_in = 1'b1; dith_en = 1'b1; vdith_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(smp_out, 10'h000, "R1");
        rst = 1'b0;
        m = 15'h0001;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        for (int c = 0; c < 16; c++)
            for (int d = 0; d < 1024; d++)
                step(10'(d), 4'(c));
        // a second reset must restart the generator from its seed
        do_reset();
        for (int d = 0; d < 2048; d++)
            step(10'((d * 37 + 5) % 1024), 4'b1010);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule